// File: doc/BRIEF.md
# Serial Memory Bus Slave Front End

This block is the two-wire bus slave that sits between a shared serial bus and a small byte-wide storage array of 128 or 256 locations. The bus clock and data wires are sampled with the core clock. The block finds bus start and stop conditions and decodes the control byte. It loads a word address and returns acknowledges and read data by pulling the data wire low through an open-drain enable.

On the storage side it presents a read address with a combinational read data return. It issues one write strobe per received data byte and a commit strobe when a write transfer is closed. A busy input from the storage side, high while an internal programming cycle runs, stops every acknowledge. Masters use that silence to poll for completion. A single address pointer serves current-address reads, random reads (address set by a write phase followed by a repeated start) and sequential reads.

Top module: `smif_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start and moves the engine to control-byte receive. A rising data line while the clock line is high is a stop and returns it to idle. Either one releases the data line at once.
- R2: The control byte arrives MSB first. Bits 7:4 must equal 1010, bits 3:1 are ignored, and bit 0 selects read (1) or write (0). On a mismatch the byte is not acknowledged, and later bytes are neither acknowledged nor written until the next start or stop.
- R3: When busy_i is high at the end of a received byte, that byte is not acknowledged and the engine waits for the next start or stop.
- R4: After a write control byte, the next byte loads the address pointer. Each later byte produces one wr_en_o pulse carrying the pointer and the byte, and then the pointer increments.
- R5: A repeated start after the word address keeps the loaded pointer, so a following read control byte reads from that address.
- R6: A read that is not preceded by a word address returns the byte at one past the last accessed location.
- R7: Read data goes out MSB first, and the pointer increments after each byte. A master acknowledge (data line low on the ninth clock) starts the next byte. A master non-acknowledge leaves the data line released until the next start or stop.
- R8: The pointer wraps from 2**AW-1 to 0 for both reads and writes.
- R9: sda_oe_o = 1 pulls the data line low. An acknowledge holds the line low through the entire high phase of the ninth clock. sda_oe_o changes only HOLD core cycles after a detected clock fall, while the clock line is low.
- R10: commit_o pulses once on a stop, and only if at least one data byte was written since the last control byte. A start does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe_o | output | 1 | 1 pulls the data wire low |
| busy_i | input | 1 | Storage programming cycle in progress |
| rd_addr_o | output | AW | Read address (the pointer) |
| rd_data_i | input | 8 | Byte at rd_addr_o, combinational |
| wr_en_o | output | 1 | One-cycle byte write strobe |
| wr_addr_o | output | AW | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| commit_o | output | 1 | One-cycle strobe: write transfer closed by stop |

## Verification
The hardest case is a transfer broken mid-stream. A repeated start lands after data bytes have already been strobed to storage. The pointer must survive that start, and no commit may follow at the next stop. The stimulus writes one byte, restarts straight into a read, and checks both the byte read at the advanced pointer and the absence of a commit. Busy refusal and the pointer wrap are reached by raising busy_i before a control byte and by loading addresses next to the top of the space.

// File: rtl/smif_pkg.sv
package smif_pkg;

    localparam logic [3:0] SMIF_DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_ACK1,
        ST_ACK2,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_WAIT
    } smif_state_e;

    typedef enum logic [1:0] {
        NX_WADDR,
        NX_WDATA,
        NX_READ
    } smif_next_e;

endpackage

// File: rtl/smif_bus_cond.sv
module smif_bus_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC-1:0] scl_sh;
        logic [SYNC-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } cond_t;

    cond_t c_q, c_d;
    logic  scl_s, sda_s;

    assign scl_s = c_q.scl_sh[SYNC-1];
    assign sda_s = c_q.sda_sh[SYNC-1];

    always_comb begin
        c_d        = c_q;
        c_d.scl_sh = {c_q.scl_sh[SYNC-2:0], scl_i};
        c_d.sda_sh = {c_q.sda_sh[SYNC-2:0], sda_i};
        c_d.scl_p  = scl_s;
        c_d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '1;
        else        c_q <= c_d;
    end

    assign scl_lvl_o = scl_s;
    assign sda_lvl_o = sda_s;
    assign start_o   = scl_s & c_q.scl_p & c_q.sda_p & ~sda_s;
    assign stop_o    = scl_s & c_q.scl_p & ~c_q.sda_p & sda_s;
    assign rise_o    = scl_s & ~c_q.scl_p;
    assign fall_o    = ~scl_s & c_q.scl_p;

endmodule

// File: rtl/smif_slave.sv
module smif_slave
    import smif_pkg::*;
#(
    parameter int AW   = 8,
    parameter int HOLD = 2,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          busy_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          commit_o
);

    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        smif_state_e   st;
        smif_next_e    nx;
        logic [2:0]    cnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic          data_seen;
        logic          want;
        logic          oe;
        logic [HW-1:0] hcnt;
        logic          wr_en;
        logic [AW-1:0] wr_addr;
        logic [7:0]    wr_data;
        logic          commit;
    } regs_t;

    regs_t r_q, r_d;

    logic scl_lvl, sda_lvl, bus_start, bus_stop, scl_rise, scl_fall;
    logic [7:0] byte_in;

    smif_bus_cond #(.SYNC(SYNC)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .start_o   (bus_start),
        .stop_o    (bus_stop),
        .rise_o    (scl_rise),
        .fall_o    (scl_fall)
    );

    assign byte_in = {r_q.sh[6:0], sda_lvl};

    always_comb begin
        r_d        = r_q;
        r_d.wr_en  = 1'b0;
        r_d.commit = 1'b0;

        // delayed update of the open-drain enable after a clock fall
        if (r_q.hcnt != '0) begin
            r_d.hcnt = r_q.hcnt - HW'(1);
            if (r_q.hcnt == HW'(1)) r_d.oe = r_q.want;
        end

        if (bus_stop) begin
            r_d.st        = ST_IDLE;
            r_d.want      = 1'b0;
            r_d.oe        = 1'b0;
            r_d.hcnt      = '0;
            r_d.commit    = r_q.data_seen;
            r_d.data_seen = 1'b0;
        end else if (bus_start) begin
            r_d.st        = ST_CTRL;
            r_d.cnt       = 3'd0;
            r_d.want      = 1'b0;
            r_d.oe        = 1'b0;
            r_d.hcnt      = '0;
            r_d.data_seen = 1'b0;
        end else begin
            case (r_q.st)
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.sh  = byte_in;
                        r_d.cnt = r_q.cnt + 3'd1;
                        if (r_q.cnt == 3'd7) begin
                            if (busy_i) begin
                                r_d.st = ST_WAIT;
                            end else if (r_q.st == ST_CTRL) begin
                                if (byte_in[7:4] == SMIF_DEV_CODE) begin
                                    r_d.st = ST_ACK1;
                                    r_d.nx = byte_in[0] ? NX_READ : NX_WADDR;
                                end else begin
                                    r_d.st = ST_WAIT;
                                end
                            end else if (r_q.st == ST_WADDR) begin
                                r_d.ptr = byte_in[AW-1:0];
                                r_d.st  = ST_ACK1;
                                r_d.nx  = NX_WDATA;
                            end else begin
                                r_d.wr_en     = 1'b1;
                                r_d.wr_addr   = r_q.ptr;
                                r_d.wr_data   = byte_in;
                                r_d.ptr       = r_q.ptr + AW'(1);
                                r_d.data_seen = 1'b1;
                                r_d.st        = ST_ACK1;
                                r_d.nx        = NX_WDATA;
                            end
                        end
                    end
                end
                ST_ACK1: begin
                    if (scl_fall) begin
                        r_d.want = 1'b1;
                        r_d.hcnt = HW'(HOLD);
                        r_d.st   = ST_ACK2;
                    end
                end
                ST_ACK2: begin
                    if (scl_fall) begin
                        r_d.hcnt = HW'(HOLD);
                        r_d.cnt  = 3'd0;
                        if (r_q.nx == NX_READ) begin
                            r_d.sh   = rd_data_i;
                            r_d.want = ~rd_data_i[7];
                            r_d.st   = ST_RDATA;
                        end else begin
                            r_d.want = 1'b0;
                            r_d.st   = (r_q.nx == NX_WADDR) ? ST_WADDR : ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        r_d.hcnt = HW'(HOLD);
                        if (r_q.cnt == 3'd7) begin
                            r_d.want = 1'b0;
                            r_d.ptr  = r_q.ptr + AW'(1);
                            r_d.st   = ST_RACK;
                        end else begin
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                            r_d.want = ~r_q.sh[6];
                            r_d.cnt  = r_q.cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) r_d.st = sda_lvl ? ST_WAIT : ST_RNEXT;
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        r_d.hcnt = HW'(HOLD);
                        r_d.cnt  = 3'd0;
                        r_d.sh   = rd_data_i;
                        r_d.want = ~rd_data_i[7];
                        r_d.st   = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe_o  = r_q.oe;
    assign rd_addr_o = r_q.ptr;
    assign wr_en_o   = r_q.wr_en;
    assign wr_addr_o = r_q.wr_addr;
    assign wr_data_o = r_q.wr_data;
    assign commit_o  = r_q.commit;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sda_oe_o); // R1
    AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK1 && $past(r_q.st) != ST_ACK1) |-> !$past(busy_i)); // R3
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (rd_addr_o == AW'(wr_addr_o + AW'(1)))); // R8
    AST_OE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl); // R9
    AST_COMMIT_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (r_q.st == ST_IDLE && !wr_en_o)); // R10

endmodule

// File: tb/smif_slave_test.sv
module smif_slave_test;

    localparam int AW = 8;
    localparam int Q  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          m_scl, m_sda, busy;
    logic          sda_oe;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0]    rd_data, wr_data;
    logic          wr_en, commit;
    wire           sda_line = m_sda & ~sda_oe;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];
    logic [15:0] exp_wr[$];
    int exp_commit = 0;
    int checks = 0;
    int fails  = 0;
    int rptr   = 0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    smif_slave #(.AW(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .busy_i    (busy),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .commit_o  (commit)
    );

    assign rd_data = mem[rd_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the storage-side strobes and the drive timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_wr.size() == 0) chk("R4 unexpected write", {wr_addr, wr_data}, 0);
                else chk("R4 write", {wr_addr, wr_data}, exp_wr.pop_front());
            end
            if (commit) begin
                chk("R10 commit expected", (exp_commit > 0) ? 1 : 0, 1);
                if (exp_commit > 0) exp_commit--;
            end
            if (sda_oe != prev_oe) chk("R9 drive change while clock high", m_scl, 0);
            prev_oe = sda_oe;
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    // returns 1 only if the line is low both early and late in the high phase
    task automatic get_ack(output bit acked);
        logic e, l;
        m_sda = 1'b1; qwait();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        e = sda_line;
        repeat (2*Q-3) @(negedge clk);
        l = sda_line;
        @(negedge clk);
        m_scl = 1'b0; qwait();
        acked = !e && !l;
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_ack(acked);
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qwait();
            m_scl = 1'b1; qwait();
            b[i] = sda_line; qwait();
            m_scl = 1'b0; qwait();
        end
        send_bit(mack ? 1'b0 : 1'b1);
    endtask

    task automatic wr_data_byte(input logic [7:0] d);
        bit a;
        exp_wr.push_back({rptr[7:0], d});
        ref_mem[rptr] = d;
        wr_byte(d, a);
        chk("R4 data ack", a, 1);
        rptr = (rptr + 1) % 256;
    endtask

    task automatic rd_expect(input bit mack, input string req);
        logic [7:0] b;
        rd_byte(b, mack);
        chk(req, b, ref_mem[rptr]);
        rptr = (rptr + 1) % 256;
    endtask

    task automatic set_addr(input logic [7:0] ctrl, input logic [7:0] a);
        bit k;
        bus_start();
        wr_byte(ctrl, k); chk("R2 write control ack", k, 1);
        wr_byte(a, k);    chk("R4 address ack", k, 1);
        rptr = a;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit k;
        logic b;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; busy = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R10 reset commit", commit, 0);
        chk("R4 reset wr_en", wr_en, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // byte/page write of three bytes, committed by stop
        set_addr(8'hA0, 8'h10);
        wr_data_byte(8'h11);
        wr_data_byte(8'h22);
        wr_data_byte(8'h33);
        exp_commit++;
        bus_stop();

        // current-address read, then NACK and one stray clock
        bus_start();
        wr_byte(8'hA1, k); chk("R6 read control ack", k, 1);
        rd_expect(1'b0, "R6 current address read");
        m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
        b = sda_line; qwait(); m_scl = 1'b0; qwait();
        chk("R7 released after NACK", b, 1);
        bus_stop();

        // random read with don't-care bits set, sequential three bytes
        set_addr(8'hAE, 8'h20);
        bus_start();
        wr_byte(8'hA3, k); chk("R5 read control ack", k, 1);
        rd_expect(1'b1, "R5 random read first byte");
        rd_expect(1'b1, "R7 sequential second byte");
        rd_expect(1'b0, "R7 sequential third byte");
        bus_stop();

        // read wrap across the top address
        set_addr(8'hA0, 8'hFE);
        bus_start();
        wr_byte(8'hA1, k); chk("R8 read control ack", k, 1);
        rd_expect(1'b1, "R8 read at FE");
        rd_expect(1'b1, "R8 read at FF");
        rd_expect(1'b0, "R8 read wrapped to 00");
        bus_stop();

        // write wrap across the top address
        set_addr(8'hA0, 8'hFF);
        wr_data_byte(8'h01);
        wr_data_byte(8'h02);
        exp_commit++;
        bus_stop();
        chk("R8 pointer after write wrap", rptr, 1);

        // busy refuses the control byte
        busy = 1'b1;
        bus_start();
        wr_byte(8'hA0, k); chk("R3 no ack while busy", k, 0);
        bus_stop();
        busy = 1'b0;

        // wrong device code: nothing acknowledged, nothing written
        bus_start();
        wr_byte(8'hB0, k); chk("R2 wrong code not acked", k, 0);
        wr_byte(8'h55, k); chk("R2 later byte ignored", k, 0);
        bus_stop();

        // write one byte then restart straight into a read: no commit
        set_addr(8'hA0, 8'h40);
        wr_data_byte(8'h99);
        bus_start();
        wr_byte(8'hA1, k); chk("R1 restart control ack", k, 1);
        rd_expect(1'b0, "R1 read after restart");
        bus_stop();
        repeat (20) @(negedge clk);

        // confirm the written byte is readable
        set_addr(8'hA0, 8'h40);
        bus_start();
        wr_byte(8'hA1, k); chk("R5 read control ack", k, 1);
        rd_expect(1'b0, "R4 stored byte readback");
        bus_stop();
        repeat (20) @(negedge clk);

        chk("R4 all writes seen", exp_wr.size(), 0);
        chk("R10 all commits seen", exp_commit, 0);
        summary();
        $finish;
    end

endmodule